// File: doc/BRIEF.md
# Event Timer Interrupt Router

This block is the output stage of a multi-channel event timer. Each channel hands it a one-cycle expiry strobe. The block turns that strobe into activity on one line of a bank of interrupt request lines, or into a message-style write request. It also holds a per-channel status word that software clears by writing ones. Counting and comparison happen upstream. The register block supplies per-channel enables, trigger type, route selection and the 64-bit message word as plain inputs.

A level-type channel latches its status bit and keeps its selected line high until the bit is cleared. An edge-type channel raises its line for exactly one cycle and leaves no status behind. A channel in message mode bypasses the pins. Its request is queued, and queued requests go out one per cycle. A legacy routing mode pins channel 0 to line 0 and channel 1 to line 8. In that mode the external real-time-clock interrupt, which normally passes through to line 8, is masked.

Top module: `irq_route_top`

## Requirements
- R1: After synchronous reset `irq_out`, `sts_q` and `msg_valid` are all zero, and `route_cap` reads 0x4 (only bit 2 set, route 2 available).
- R2: An expiry on a live channel (global enable and channel enable both 1) whose type input is 1 (level) and whose message mode is off sets `sts_q[i]` at the clock edge that samples it. Its routed line is high from then on and stays high until the bit is cleared.
- R3: An expiry on a live channel whose type input is 0 (edge) and whose message mode is off drives its routed line high for exactly one cycle after the sampling edge and leaves `sts_q[i]` at 0.
- R4: A cycle with `sts_wr`=1 clears every status bit whose `sts_wdata` bit is 1 and leaves bits written with 0 unchanged. If an expiry and a clear hit the same bit in the same cycle, the expiry wins.
- R5: While the global enable or a channel's enable is 0, that channel's status bit is cleared, its line is low, and its expiries produce no status, pulse or message.
- R6: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8. All other channels, and every channel with legacy mode off, drive the line given by their 5-bit route field (`ch_route[5i+4:5i]`).
- R7: The external clock interrupt appears on line 8 one cycle after it is sampled, but only while legacy mode is off. Entering legacy mode lowers line 8, and leaving it shows the current input level again.
- R8: An expiry on a live channel in message mode raises `msg_valid` for one cycle, at the earliest one cycle after the sampling edge. It carries `msg_addr` = bits 63:32 and `msg_data` = bits 31:0 of that channel's message word. It sets no status bit and drives no line.
- R9: A 0-to-1 change of a channel's message-mode input clears that channel's status bit, which lowers its line.
- R10: Message requests that are pending together are issued one per cycle, lowest channel number first, and none is lost.
- R11: A line selected by several sources is the OR of all held and pulsed requests routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy routing mode |
| ch_en | input | N_CH | Per-channel interrupt enable |
| ch_level | input | N_CH | Trigger type, 1 = level, 0 = edge |
| ch_msg_en | input | N_CH | Per-channel message mode |
| ch_route | input | N_CH*ROUTE_W | Per-channel line select |
| ch_msg_word | input | N_CH*2*MSG_W | Per-channel message word, address in upper half |
| expire | input | N_CH | One-cycle expiry strobes |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | N_CH | Status write data, ones clear |
| rtc_irq | input | 1 | External real-time-clock interrupt level |
| irq_out | output | N_LINES | Interrupt request lines |
| sts_q | output | N_CH | Status register |
| msg_valid | output | 1 | Message write request strobe |
| msg_addr | output | MSG_W | Message address |
| msg_data | output | MSG_W | Message data |
| route_cap | output | N_LINES | Advertised route capability mask |

## Verification
A corrupted status bit shows on the routed line in the cycle after the bad edge. It then stays wrong until a clear, so a stuck or lost level request is seen at the first sample after an expiry or a write-one-to-clear. A wrong route or legacy override lights the wrong bit of `irq_out` in that same cycle. A fault in the pending-message queue shows as a missing, duplicated or reordered `msg_valid` beat within a few cycles. The scoreboard catches that as an unexpected item or a queue that never drains.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int LINE_LEG_CH0  = 0;
    localparam int LINE_LEG_CH1  = 8;
    localparam int LINE_CLK_PASS = 8;
    localparam int CAP_ROUTE_BIT = 2;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_HOLD  = 2'd1,
        EV_PULSE = 2'd2,
        EV_MSG   = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } msg_beat_t;

    // Decide what a single expiry strobe turns into.
    function automatic ev_kind_e classify_ev(logic live, logic fire,
                                             logic level, logic msg);
        if (!live || !fire) return EV_NONE;
        if (msg)            return EV_MSG;
        if (level)          return EV_HOLD;
        return EV_PULSE;
    endfunction

    // Destination line of a channel, legacy override applied.
    function automatic int pick_line(int ch, logic legacy, int route_val);
        if (legacy && ch == 0) return LINE_LEG_CH0;
        if (legacy && ch == 1) return LINE_LEG_CH1;
        return route_val;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_route_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            glb_en,
    input  logic [N_CH-1:0] ch_en,
    input  logic [N_CH-1:0] ch_level,
    input  logic [N_CH-1:0] ch_msg_en,
    input  logic [N_CH-1:0] expire,
    input  logic            sts_wr,
    input  logic [N_CH-1:0] sts_wdata,
    output logic [N_CH-1:0] sts_q,
    output logic [N_CH-1:0] pulse_q,
    output logic [N_CH-1:0] msg_req
);

    logic [N_CH-1:0] msg_prev_q;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic     live;
        logic     msg_rise;
        logic     wr_clr;
        ev_kind_e kind;

        always_comb begin
            live     = glb_en & ch_en[i];
            msg_rise = ch_msg_en[i] & ~msg_prev_q[i];
            wr_clr   = sts_wr & sts_wdata[i];
            kind     = classify_ev(live, expire[i], ch_level[i], ch_msg_en[i]);
            msg_req[i] = (kind == EV_MSG);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[i]      <= 1'b0;
                pulse_q[i]    <= 1'b0;
                msg_prev_q[i] <= 1'b0;
            end else begin
                msg_prev_q[i] <= ch_msg_en[i];
                pulse_q[i]    <= (kind == EV_PULSE);
                if (kind == EV_HOLD) begin
                    sts_q[i] <= 1'b1;
                end else if (!live || msg_rise || wr_clr) begin
                    sts_q[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_route_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int MSG_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CH-1:0]         msg_req,
    input  logic [N_CH*2*MSG_W-1:0] ch_msg_word,
    output logic                    msg_valid,
    output logic [MSG_W-1:0]        msg_addr,
    output logic [MSG_W-1:0]        msg_data
);

    localparam int WORD_W = 2 * MSG_W;

    logic [N_CH-1:0]   pend_q;
    logic [N_CH-1:0]   grant_oh;
    logic              any_pend;
    int                win_idx;
    logic [WORD_W-1:0] win_word;

    always_comb begin
        any_pend = 1'b0;
        win_idx  = 0;
        for (int c = 0; c < N_CH; c++) begin
            if (!any_pend && pend_q[c]) begin
                any_pend = 1'b1;
                win_idx  = c;
            end
        end
        grant_oh = any_pend ? (N_CH'(1) << win_idx) : '0;
        win_word = ch_msg_word[win_idx*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else begin
            pend_q    <= (pend_q & ~grant_oh) | msg_req;
            msg_valid <= any_pend;
            if (any_pend) begin
                msg_addr <= win_word[WORD_W-1:MSG_W];
                msg_data <= win_word[MSG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
    import irq_route_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int N_LINES = 24,
    parameter int ROUTE_W = 5
) (
    input  logic                    legacy_en,
    input  logic [N_CH*ROUTE_W-1:0] ch_route,
    input  logic [N_CH-1:0]         src_active,
    input  logic                    clk_irq_q,
    output logic [N_LINES-1:0]      lines
);

    localparam int LW = $clog2(N_LINES);

    always_comb begin
        lines = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            int tgt;
            tgt = pick_line(ch, legacy_en, int'(ch_route[ch*ROUTE_W +: ROUTE_W]));
            if (src_active[ch] && tgt < N_LINES) begin
                lines[LW'(tgt)] = 1'b1;
            end
        end
        if (!legacy_en && clk_irq_q) begin
            lines[LINE_CLK_PASS] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int N_LINES = 24,
    parameter int ROUTE_W = 5,
    parameter int MSG_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    glb_en,
    input  logic                    legacy_en,
    input  logic [N_CH-1:0]         ch_en,
    input  logic [N_CH-1:0]         ch_level,
    input  logic [N_CH-1:0]         ch_msg_en,
    input  logic [N_CH*ROUTE_W-1:0] ch_route,
    input  logic [N_CH*2*MSG_W-1:0] ch_msg_word,
    input  logic [N_CH-1:0]         expire,
    input  logic                    sts_wr,
    input  logic [N_CH-1:0]         sts_wdata,
    input  logic                    rtc_irq,
    output logic [N_LINES-1:0]      irq_out,
    output logic [N_CH-1:0]         sts_q,
    output logic                    msg_valid,
    output logic [MSG_W-1:0]        msg_addr,
    output logic [MSG_W-1:0]        msg_data,
    output logic [N_LINES-1:0]      route_cap
);

    localparam logic [N_LINES-1:0] CAP_MASK = N_LINES'(1) << CAP_ROUTE_BIT;

    logic [N_CH-1:0] pulse_q;
    logic [N_CH-1:0] msg_req;
    logic            rtc_q;

    always_ff @(posedge clk) begin
        if (rst) rtc_q <= 1'b0;
        else     rtc_q <= rtc_irq;
    end

    assign route_cap = CAP_MASK;

    irq_status_bank #(.N_CH(N_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .glb_en    (glb_en),
        .ch_en     (ch_en),
        .ch_level  (ch_level),
        .ch_msg_en (ch_msg_en),
        .expire    (expire),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .sts_q     (sts_q),
        .pulse_q   (pulse_q),
        .msg_req   (msg_req)
    );

    irq_msg_arb #(.N_CH(N_CH), .MSG_W(MSG_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .msg_req     (msg_req),
        .ch_msg_word (ch_msg_word),
        .msg_valid   (msg_valid),
        .msg_addr    (msg_addr),
        .msg_data    (msg_data)
    );

    irq_line_mux #(.N_CH(N_CH), .N_LINES(N_LINES), .ROUTE_W(ROUTE_W)) u_mux (
        .legacy_en  (legacy_en),
        .ch_route   (ch_route),
        .src_active (sts_q | pulse_q),
        .clk_irq_q  (rtc_q),
        .lines      (irq_out)
    );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int N_CH    = 4,
    parameter int N_LINES = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               glb_en,
    input logic               legacy_en,
    input logic [N_CH-1:0]    ch_en,
    input logic [N_CH-1:0]    ch_level,
    input logic [N_CH-1:0]    ch_msg_en,
    input logic [N_CH-1:0]    expire,
    input logic               sts_wr,
    input logic [N_CH-1:0]    sts_wdata,
    input logic [N_LINES-1:0] irq_out,
    input logic [N_CH-1:0]    sts_q
);

    AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (rst)
        (glb_en && ch_en[0] && ch_level[0] && !ch_msg_en[0] && expire[0]) |=> sts_q[0]); // R2

    AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (glb_en && ch_en[0] && !ch_level[0] && !ch_msg_en[0] && expire[0] && !sts_q[0]) |=> !sts_q[0]); // R3

    AST_W1C_ONE: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && sts_wdata[0] && !expire[0]) |=> !sts_q[0]); // R4

    AST_W1C_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && !sts_wdata[0] && sts_q[0] && glb_en && ch_en[0] && !ch_msg_en[0]) |=> sts_q[0]); // R4

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> (sts_q == '0)); // R5

    AST_LEGACY_CH0: assert property (@(posedge clk) disable iff (rst)
        (legacy_en && sts_q[0]) |-> irq_out[0]); // R6

endmodule

bind irq_route_top irq_route_chk #(.N_CH(N_CH), .N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .glb_en    (glb_en),
    .legacy_en (legacy_en),
    .ch_en     (ch_en),
    .ch_level  (ch_level),
    .ch_msg_en (ch_msg_en),
    .expire    (expire),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .irq_out   (irq_out),
    .sts_q     (sts_q)
);

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;

    localparam int N_CH    = 4;
    localparam int N_LINES = 24;
    localparam int ROUTE_W = 5;
    localparam int MSG_W   = 32;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    glb_en = 1'b0;
    logic                    legacy_en = 1'b0;
    logic [N_CH-1:0]         ch_en = '0;
    logic [N_CH-1:0]         ch_level = '0;
    logic [N_CH-1:0]         ch_msg_en = '0;
    logic [N_CH*ROUTE_W-1:0] ch_route = '0;
    logic [N_CH*2*MSG_W-1:0] ch_msg_word = '0;
    logic [N_CH-1:0]         expire = '0;
    logic                    sts_wr = 1'b0;
    logic [N_CH-1:0]         sts_wdata = '0;
    logic                    rtc_irq = 1'b0;
    logic [N_LINES-1:0]      irq_out;
    logic [N_CH-1:0]         sts_q;
    logic                    msg_valid;
    logic [MSG_W-1:0]        msg_addr;
    logic [MSG_W-1:0]        msg_data;
    logic [N_LINES-1:0]      route_cap;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] exp_q[$];

    always #10 clk = ~clk;

    irq_route_top #(.N_CH(N_CH), .N_LINES(N_LINES), .ROUTE_W(ROUTE_W), .MSG_W(MSG_W)) u_dut (
        .clk(clk), .rst(rst), .glb_en(glb_en), .legacy_en(legacy_en),
        .ch_en(ch_en), .ch_level(ch_level), .ch_msg_en(ch_msg_en),
        .ch_route(ch_route), .ch_msg_word(ch_msg_word), .expire(expire),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .rtc_irq(rtc_irq),
        .irq_out(irq_out), .sts_q(sts_q), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .route_cap(route_cap)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Strobe expiries for one edge; returns just after that edge has been sampled.
    task automatic fire(input logic [N_CH-1:0] m);
        @(negedge clk); expire = m;
        @(negedge clk); expire = '0;
    endtask

    task automatic w1c(input logic [N_CH-1:0] m);
        @(negedge clk); sts_wr = 1'b1; sts_wdata = m;
        @(negedge clk); sts_wr = 1'b0; sts_wdata = '0;
    endtask

    task automatic push_msg(input int ch);
        exp_q.push_back(ch_msg_word[ch*64 +: 64]);
    endtask

    // Monitor: pop the next expected message whenever a beat appears.
    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10 actual=%h expected=none", {msg_addr, msg_data});
            end else begin
                check("R8 R10 message beat", {msg_addr, msg_data}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_CH; i++)
            ch_msg_word[i*64 +: 64] = {32'hA000_0000 + 32'(i), 32'hD000_0000 + 32'(i)};
        ch_route = {5'd10, 5'd5, 5'd5, 5'd3};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq_out", 64'(irq_out), 0);
        check("R1 sts_q", 64'(sts_q), 0);
        check("R1 msg_valid", 64'(msg_valid), 0);
        check("R1 route_cap", 64'(route_cap), 64'h4);

        glb_en = 1'b1; ch_en = 4'hF; ch_level = 4'b1101;

        // R2 level hold
        fire(4'b0001);
        check("R2 status set", 64'(sts_q), 64'h1);
        check("R2 line 3 high", 64'(irq_out), 64'h8);
        repeat (3) @(negedge clk);
        check("R2 line held", 64'(irq_out), 64'h8);

        // R4 write zero, then write one
        w1c(4'b0000);
        check("R4 zero write no effect", 64'(sts_q), 64'h1);
        w1c(4'b0001);
        check("R4 clear status", 64'(sts_q), 0);
        check("R4 line dropped", 64'(irq_out), 0);

        // R3 edge pulse
        fire(4'b0010);
        check("R3 pulse on line 5", 64'(irq_out), 64'h20);
        check("R3 no status", 64'(sts_q), 0);
        @(negedge clk);
        check("R3 pulse one cycle", 64'(irq_out), 0);

        // R11 shared line
        fire(4'b0100);
        fire(4'b0010);
        check("R11 shared line", 64'(irq_out), 64'h20);
        w1c(4'b0100);
        check("R11 line low after clear", 64'(irq_out), 0);

        // R4 expiry beats clear
        @(negedge clk); expire = 4'b0001; sts_wr = 1'b1; sts_wdata = 4'b0001;
        @(negedge clk); expire = '0; sts_wr = 1'b0; sts_wdata = '0;
        check("R4 expiry wins", 64'(sts_q), 64'h1);

        // R5 channel disable, global disable
        @(negedge clk); ch_en = 4'b1110;
        @(negedge clk);
        check("R5 channel off clears", 64'(sts_q), 0);
        check("R5 channel off line", 64'(irq_out), 0);
        fire(4'b0001);
        check("R5 expiry ignored", 64'(sts_q), 0);
        check("R5 expiry no line", 64'(irq_out), 0);
        ch_en = 4'hF;
        fire(4'b1000);
        check("R6 route field line 10", 64'(irq_out), 64'h400);
        @(negedge clk); glb_en = 1'b0;
        @(negedge clk);
        check("R5 global off clears", 64'(sts_q), 0);
        check("R5 global off line", 64'(irq_out), 0);
        glb_en = 1'b1;

        // R6 legacy routing
        legacy_en = 1'b1;
        fire(4'b0001);
        check("R6 legacy ch0 line 0", 64'(irq_out), 64'h1);
        w1c(4'b0001);
        fire(4'b0010);
        check("R6 legacy ch1 line 8", 64'(irq_out), 64'h100);
        @(negedge clk);
        fire(4'b1000);
        check("R6 legacy other uses route", 64'(irq_out), 64'h400);
        w1c(4'b1000);
        legacy_en = 1'b0;

        // R7 clock interrupt passthrough
        @(negedge clk); rtc_irq = 1'b1;
        @(negedge clk);
        check("R7 passthrough", 64'(irq_out), 64'h100);
        legacy_en = 1'b1;
        @(negedge clk);
        check("R7 masked in legacy", 64'(irq_out), 0);
        legacy_en = 1'b0;
        @(negedge clk);
        check("R7 restored", 64'(irq_out), 64'h100);
        rtc_irq = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R7 follows input", 64'(irq_out), 0);

        // R9 message enable clears held status
        fire(4'b0100);
        check("R9 precondition", 64'(sts_q), 64'h4);
        @(negedge clk); ch_msg_en = 4'b0100;
        @(negedge clk);
        check("R9 status cleared", 64'(sts_q), 0);
        check("R9 line lowered", 64'(irq_out), 0);

        // R8 / R10 messages, lowest channel first
        ch_msg_en = 4'b1110;
        push_msg(1); push_msg(2); push_msg(3);
        fire(4'b1110);
        check("R8 no pin", 64'(irq_out), 0);
        check("R8 no status", 64'(sts_q), 0);
        repeat (5) @(negedge clk);
        check("R10 all issued", 64'(exp_q.size()), 0);
        check("R8 valid is a pulse", 64'(msg_valid), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule